// File: doc/BRIEF.md
# TDM Daisy-Chain Slot Tracker

This block finds one device's timeslot inside a time-division multiplexed serial frame. Up to four devices share the serial clock, the frame sync and the data lines. Each device owns one 64-bit word of the frame, and the frame length is a multiple of 64 bits. With four devices the frame is 256 bits. A one-clock pulse on `chain_in` marks the first bit of this device's word. The first device in the chain takes the frame sync as its `chain_in`. Every later device takes the `chain_out` of the device before it.

From that pulse the block counts the word's bit periods, most significant bit first. While the word is on the lines it raises `slot_active`, and it gives the index of the current bit on `bit_idx`. Transmit and receive logic use these two outputs to gate their shift registers. During the last bit of the word the block raises `chain_out` for one clock, which starts the next device's word.

Raising `pwr_dn` turns the block into a wire from `chain_in` to `chain_out`. The devices further down the chain then move up by one word, and no device needs reprogramming. The block has no data stream of its own, so all of its pins are plain control and status signals with no valid/ready handshake.

Top module: `tdm_slot_tracker`

## Requirements
- R1: While `rst_n` is low, `chain_out`, `slot_active` and `bit_idx` are all 0, whatever `pwr_dn` and `chain_in` are doing. A reset in the middle of a word abandons that word, and after reset is released the block stays idle until the next `chain_in`.
- R2: In the clock period in which `chain_in` is high (with `pwr_dn` low), `slot_active` is 1 and `bit_idx` is 63. The first bit is not delayed by any cycle.
- R3: While a word is in progress, `bit_idx` drops by exactly one on each clock, from 63 down to 0.
- R4: A single `chain_in` pulse makes `slot_active` high for exactly 64 consecutive clock periods. In the period after `bit_idx` 0 it is low and `bit_idx` is 0.
- R5: When `pwr_dn` is low, `chain_out` is 1 only in the period where `slot_active` is 1 and `bit_idx` is 0. The pulse is exactly one clock wide.
- R6: A `chain_in` pulse that arrives while a word is in progress restarts the count. `bit_idx` becomes 63 in that period, and a full 64-period word follows.
- R7: While `pwr_dn` is 1 and `rst_n` is 1, `chain_out` follows `chain_in` combinationally within the same clock period.
- R8: While `pwr_dn` is 1, `slot_active` is 0 and `bit_idx` is 0, and any word in progress is dropped. After `pwr_dn` falls, the block stays idle until the next `chain_in`.
- R9: Words can run back to back. A `chain_in` in the period right after `bit_idx` 0 starts a new word at 63. In a 256-bit frame, `chain_out` fires once in each frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock. Inputs are sampled on its rising edge. |
| rst_n | input | 1 | Active-low asynchronous reset. |
| pwr_dn | input | 1 | Active-high power-down. Selects the chain pass-through. |
| chain_in | input | 1 | One-clock pulse that marks the first bit of this device's word. |
| slot_active | output | 1 | High while this device's word is on the serial lines. |
| bit_idx | output | 6 | Index of the current bit in the word: 63 first, 0 last. |
| chain_out | output | 1 | One-clock pulse on the last bit of the word. Equals `chain_in` during power-down. |

## Verification
The results are due at two different times.
- **Combinational results:** the start of a word (`slot_active` and `bit_idx` 63), the power-down pass-through and the reset clearing all follow the inputs within the same clock period.
- **Registered results:** each following `bit_idx` value and the `chain_out` pulse come one register later per clock, so the last bit falls 63 clocks after the `chain_in` period.

The bench changes inputs on the falling edge and samples outputs 1 ns later, before the next rising edge. It therefore reads each period's combinational value together with the value the counter registered on the rising edge before. The expected index is counted in the bench from the number of clocks since the pulse.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;

  // Default word length owned by one device in the frame.
  localparam int unsigned WORD_BITS_DEF = 64;

  // Counter state of the slot tracker.
  typedef enum logic {
    SLOT_IDLE = 1'b0,
    SLOT_BUSY = 1'b1
  } slot_state_e;

endpackage

// File: rtl/tdm_bit_counter.sv
module tdm_bit_counter
  import tdm_slot_pkg::*;
#(
  parameter int unsigned WORD_BITS = WORD_BITS_DEF,
  localparam int unsigned IDX_W = $clog2(WORD_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_clr,   // synchronous clear (power-down)
  input  logic             start,      // first bit of the word is now on the line
  output logic             busy_o,
  output logic [IDX_W-1:0] cur_idx_o
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WORD_BITS - 1);

  slot_state_e      state_q;
  logic [IDX_W-1:0] cnt_q;

  // The start bit is served in the same period: no latency before the top index.
  always_comb begin
    busy_o    = start || (state_q == SLOT_BUSY);
    cur_idx_o = start ? TOP_IDX : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SLOT_IDLE;
      cnt_q   <= '0;
    end else if (hold_clr) begin
      state_q <= SLOT_IDLE;
      cnt_q   <= '0;
    end else if (start) begin
      state_q <= SLOT_BUSY;
      cnt_q   <= TOP_IDX - IDX_W'(1);
    end else if (state_q == SLOT_BUSY) begin
      if (cnt_q == '0) begin
        state_q <= SLOT_IDLE;
      end else begin
        cnt_q <= cnt_q - IDX_W'(1);
      end
    end
  end

  // R3: once started, the held index only ever moves down by one or restarts.
  p_held_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SLOT_BUSY && !start && !hold_clr && cnt_q != '0)
      |=> (cnt_q == $past(cnt_q) - IDX_W'(1)));

endmodule

// File: rtl/tdm_chain_mux.sv
module tdm_chain_mux #(
  parameter int unsigned IDX_W = 6
) (
  input  logic             rst_n,
  input  logic             pwr_dn,
  input  logic             chain_in,
  input  logic             slot_active,
  input  logic [IDX_W-1:0] bit_idx,
  output logic             chain_out
);

  logic last_bit;

  always_comb begin
    last_bit = slot_active && (bit_idx == '0);
    if (!rst_n) begin
      chain_out = 1'b0;
    end else if (pwr_dn) begin
      chain_out = chain_in;
    end else begin
      chain_out = last_bit;
    end
  end

endmodule

// File: rtl/tdm_slot_tracker.sv
module tdm_slot_tracker
  import tdm_slot_pkg::*;
#(
  parameter int unsigned WORD_BITS = WORD_BITS_DEF,
  localparam int unsigned IDX_W = $clog2(WORD_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_dn,
  input  logic             chain_in,
  output logic             slot_active,
  output logic [IDX_W-1:0] bit_idx,
  output logic             chain_out
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WORD_BITS - 1);

  logic             start;
  logic             cnt_busy;
  logic [IDX_W-1:0] cnt_idx;

  assign start = chain_in && !pwr_dn;

  tdm_bit_counter #(
    .WORD_BITS (WORD_BITS)
  ) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_clr  (pwr_dn),
    .start     (start),
    .busy_o    (cnt_busy),
    .cur_idx_o (cnt_idx)
  );

  // Power-down and reset both mask the slot outputs.
  always_comb begin
    slot_active = cnt_busy && !pwr_dn && rst_n;
    bit_idx     = slot_active ? cnt_idx : '0;
  end

  tdm_chain_mux #(
    .IDX_W (IDX_W)
  ) u_chain (
    .rst_n       (rst_n),
    .pwr_dn      (pwr_dn),
    .chain_in    (chain_in),
    .slot_active (slot_active),
    .bit_idx     (bit_idx),
    .chain_out   (chain_out)
  );

  // R1: nothing leaves the block while reset is held.
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!chain_out && !slot_active && bit_idx == '0);
    end
  end

  // R2: the pulse period already carries the top bit.
  p_first_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_in && !pwr_dn) |-> (slot_active && bit_idx == TOP_IDX));

  // R3: the index steps down by one unless restarted or powered down.
  p_countdown_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_active && bit_idx != '0 && !pwr_dn)
      |=> (pwr_dn || chain_in || (slot_active && bit_idx == $past(bit_idx) - IDX_W'(1))));

  // R4: the slot closes after its last bit unless a new word begins.
  p_word_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_active && bit_idx == '0 && !pwr_dn) |=> (!slot_active || chain_in || pwr_dn));

  // R5: the chain-out pulse is a single clock wide.
  p_out_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_out && !pwr_dn) |=> (!chain_out || pwr_dn));

  // R7: power-down passes the chain straight through.
  p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> (chain_out == chain_in));

  // R8: no slot activity while powered down.
  p_pd_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> (!slot_active && bit_idx == '0));

endmodule

// File: tb/test_tdm_slot_tracker.sv
module test_tdm_slot_tracker;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pwr_dn;
  logic       chain_in;
  logic       slot_active;
  logic [5:0] bit_idx;
  logic       chain_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  tdm_slot_tracker i_tdm_slot_tracker (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_dn      (pwr_dn),
    .chain_in    (chain_in),
    .slot_active (slot_active),
    .bit_idx     (bit_idx),
    .chain_out   (chain_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Compare all three outputs against expected values.
  task automatic expect_out(input string req, input bit act_e, input int idx_e, input bit out_e);
    check(slot_active == act_e, {req, " slot_active"}, int'(slot_active), int'(act_e));
    check(int'(bit_idx) == idx_e, {req, " bit_idx"}, int'(bit_idx), idx_e);
    check(chain_out == out_e, {req, " chain_out"}, int'(chain_out), int'(out_e));
  endtask

  // Advance one period: drive on the falling edge, sample 1 ns later.
  task automatic step(input bit cin);
    @(negedge clk);
    chain_in = cin;
    #1;
  endtask

  // Check the remaining 63 bits of a word that started one period earlier.
  task automatic run_tail(input string req);
    for (int k = 1; k < 64; k++) begin
      step(1'b0);
      expect_out(req, 1'b1, 63 - k, (k == 63));
    end
  endtask

  task automatic t_reset_r1;
    rst_n = 1'b0; pwr_dn = 1'b1; chain_in = 1'b1;
    #1;
    expect_out("R1 reset with pd", 1'b0, 0, 1'b0);
    pwr_dn = 1'b0;
    repeat (2) step(1'b1);
    expect_out("R1 reset no pd", 1'b0, 0, 1'b0);
    step(1'b0);
    rst_n = 1'b1;
    step(1'b0);
    expect_out("R1 idle after reset", 1'b0, 0, 1'b0);
  endtask

  task automatic t_single_word_r2_r3_r4_r5;
    step(1'b1);
    expect_out("R2 first bit", 1'b1, 63, 1'b0);
    run_tail("R3 R5 countdown");
    step(1'b0);
    expect_out("R4 after last bit", 1'b0, 0, 1'b0);
    step(1'b0);
    expect_out("R4 stays idle", 1'b0, 0, 1'b0);
  endtask

  task automatic t_restart_r6;
    step(1'b1);
    for (int k = 1; k <= 20; k++) step(1'b0);
    check(int'(bit_idx) == 43, "R6 before restart", int'(bit_idx), 43);
    step(1'b1);
    expect_out("R6 restart", 1'b1, 63, 1'b0);
    run_tail("R6 full word after restart");
    step(1'b0);
    expect_out("R6 end", 1'b0, 0, 1'b0);
  endtask

  task automatic t_powerdown_r7_r8;
    step(1'b1);
    for (int k = 1; k <= 10; k++) step(1'b0);
    @(negedge clk);
    pwr_dn = 1'b1;
    #1;
    expect_out("R8 pd drops word", 1'b0, 0, 1'b0);
    chain_in = 1'b1;
    #0.5;
    check(chain_out == 1'b1, "R7 pass high", int'(chain_out), 1);
    check(slot_active == 1'b0, "R8 pd ignores chain_in", int'(slot_active), 0);
    chain_in = 1'b0;
    #0.5;
    check(chain_out == 1'b0, "R7 pass low", int'(chain_out), 0);
    step(1'b1);
    check(chain_out == 1'b1, "R7 pass across edge", int'(chain_out), 1);
    step(1'b0);
    @(negedge clk);
    pwr_dn = 1'b0;
    #1;
    expect_out("R8 idle after pd", 1'b0, 0, 1'b0);
    step(1'b0);
    expect_out("R8 still idle", 1'b0, 0, 1'b0);
  endtask

  task automatic t_back_to_back_r9;
    int pulses = 0;
    for (int f = 0; f < 3; f++) begin
      step(1'b1);
      check(int'(bit_idx) == 63, "R9 word start", int'(bit_idx), 63);
      for (int k = 1; k < 64; k++) begin
        step(1'b0);
        if (chain_out) pulses++;
      end
      // Idle for the other three words of a 256-bit frame, except the last one.
      if (f < 2) begin
        for (int k = 0; k < 192; k++) begin
          step(1'b0);
          if (chain_out) pulses++;
        end
      end
    end
    check(pulses == 3, "R9 one chain_out per frame", pulses, 3);
    // Immediate follow-on word.
    step(1'b1);
    expect_out("R9 back to back start", 1'b1, 63, 1'b0);
    run_tail("R9 back to back word");
    step(1'b0);
  endtask

  task automatic t_reset_midword_r1;
    step(1'b1);
    for (int k = 1; k <= 5; k++) step(1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    expect_out("R1 mid-word reset", 1'b0, 0, 1'b0);
    step(1'b0);
    rst_n = 1'b1;
    step(1'b0);
    expect_out("R1 word abandoned", 1'b0, 0, 1'b0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset_r1();
    t_single_word_r2_r3_r4_r5();
    t_restart_r6();
    t_powerdown_r7_r8();
    t_back_to_back_r9();
    t_reset_midword_r1();
    finish_run();
  end

endmodule